// File: doc/BRIEF.md
# Transmit Backoff and Spacing Scheduler

This block decides the cycle in which a queued transmit packet is allowed to start. A start request arrives with the packet's current load word. The block writes back a grown load, draws a fresh 16-bit pseudo-random number and masks its upper byte with the load to form a backoff. A nonzero backoff is waited out in 16 microsecond ticks. A zero backoff falls through to a spacing rule: the time since the last successful transmission, read from a free-running 32 microsecond counter, must reach a programmed minimum gap. The block then issues a single-cycle go pulse.

After go, the block waits for the transmitter's end indication. A collision retries the packet through the same path, using the load it wrote back, with no new request. A clean finish records the end time for later spacing checks. A non-collision abort ends the packet and leaves the record unchanged. A load with its top bit set stops the packet with an overflow pulse and no transmission. Moving the data is handled elsewhere.

Top module: `tx_backoff_sched`

## Requirements
- R1: Each evaluation writes back `load_o = (2*cur + 1) mod 2^16` and pulses `load_we_o` in the cycle after the sampling edge. `cur` is `load_i` for a request and the held `load_o` for a retry.
- R2: If bit 15 of `cur` is set, `ovf_o` pulses together with `load_we_o`, no go follows for that packet, and the block returns to idle.
- R3: The random state resets to 16'hACE1. It advances once per evaluation, overflow evaluations included, as `R = (R*2053 + 13849) mod 2^16`.
- R4: The backoff is `2*(cur[7:0] & R_new[15:8])`. When it is nonzero, `go_o` rises at the edge that samples the backoff-th `tick_i` after the evaluation edge.
- R5: With a zero backoff, the elapsed time is `e = (time_i - last_end) mod 2^16`. If `e < min_gap_i`, go comes on the `2*(min_gap_i - e)`-th tick. Otherwise go pulses together with `load_we_o`.
- R6: `go_o` is high for exactly one cycle. Ticks count only while a wait is in progress, and only one wait runs at a time.
- R7: `tx_end_i` with `tx_coll_i` high starts a new evaluation one cycle later using the held load, with no request.
- R8: `tx_end_i` with `tx_coll_i` and `tx_fail_i` both low stores `time_i` as `last_end`. `last_end` resets to 0.
- R9: `tx_end_i` with `tx_fail_i` high and `tx_coll_i` low returns the block to idle and leaves `last_end` unchanged.
- R10: `req_i` is ignored unless the block is idle: no load write, and the running wait is undisturbed.
- R11: After reset `go_o`, `ovf_o` and `load_we_o` are low and `load_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request for a packet |
| load_i | input | 16 | Current load word of the packet |
| min_gap_i | input | 16 | Minimum inter-packet gap, 32 us units |
| time_i | input | 16 | Free-running 32 us time counter |
| tick_i | input | 1 | 16 us tick pulse |
| tx_end_i | input | 1 | Transmit ended |
| tx_coll_i | input | 1 | Transmit ended by collision |
| tx_fail_i | input | 1 | Transmit aborted for another reason |
| load_o | output | 16 | Written-back load |
| load_we_o | output | 1 | Load write strobe, one per evaluation |
| go_o | output | 1 | Transmit may start (one cycle) |
| ovf_o | output | 1 | Load overflow, packet dropped |

## Verification
The load write and any overflow are due in the cycle after the request edge. A retry's load write comes one cycle after the collision end edge. Go is due either together with the load write, when no wait is needed, or at the edge that samples the last tick of the wait. The bench checks the load strobe on the first falling edge after each request. Its monitor records a tick count when the load write is seen and compares it with the tick count when go is seen, so the number of ticks that elapsed must equal the wait that a bench-side model of the generator, mask and spacing rule predicts.

// File: rtl/tx_bo_pkg.sv
package tx_bo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_TX    = 2'd2,
    ST_RETRY = 2'd3
  } bo_state_e;
endpackage

// File: rtl/tx_bo_rng.sv
module tx_bo_rng #(
  parameter int unsigned RW   = 16,
  parameter int unsigned SEED = 16'hACE1,
  parameter int unsigned RMUL = 2053,
  parameter int unsigned RADD = 13849
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [RW-1:0] nxt_o
);
  localparam logic [RW-1:0] MUL = RW'(RMUL);
  localparam logic [RW-1:0] ADD = RW'(RADD);
  localparam logic [RW-1:0] INI = RW'(SEED);

  logic [RW-1:0] r_q;

  assign nxt_o = r_q * MUL + ADD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    r_q <= INI;
    else if (adv_i) r_q <= nxt_o;
  end

  // R3: state moves to the advertised next value only when advanced
  a_r3_rng_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> r_q == $past(nxt_o));
endmodule

// File: rtl/tx_bo_calc.sv
module tx_bo_calc #(
  parameter int unsigned LW = 16,
  parameter int unsigned RW = 16,
  parameter int unsigned TW = 16,
  parameter int unsigned MB = 8,
  parameter int unsigned CW = 17
) (
  input  logic [LW-1:0] cur_i,
  input  logic [RW-1:0] rnd_i,
  input  logic [TW-1:0] time_i,
  input  logic [TW-1:0] last_i,
  input  logic [TW-1:0] gap_i,
  output logic          ovf_o,
  output logic [LW-1:0] new_load_o,
  output logic [CW-1:0] wait_o
);
  logic [MB-1:0] mask;
  logic [TW-1:0] elapsed, short;

  assign new_load_o = {cur_i[LW-2:0], 1'b1};
  assign ovf_o      = cur_i[LW-1];
  assign mask       = cur_i[MB-1:0] & rnd_i[RW-1 -: MB];
  assign elapsed    = time_i - last_i;
  assign short      = gap_i - elapsed;

  // wait counted in 16 us ticks, both sources doubled from 32 us units
  always_comb begin
    if (mask != '0)           wait_o = CW'({mask, 1'b0});
    else if (elapsed < gap_i) wait_o = CW'({short, 1'b0});
    else                      wait_o = '0;
  end
endmodule

// File: rtl/tx_bo_wait.sv
module tx_bo_wait #(
  parameter int unsigned CW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  input  logic          tick_i,
  output logic          active_o,
  output logic          fire_o
);
  logic [CW-1:0] cnt_q;

  assign active_o = cnt_q != '0;
  assign fire_o   = tick_i && cnt_q == CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i)            cnt_q <= len_i;
    else if (tick_i && active_o) cnt_q <= cnt_q - CW'(1);
  end

  // R6: a new wait never starts over a running one
  a_r6_single_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cnt_q == '0);
endmodule

// File: rtl/tx_backoff_sched.sv
module tx_backoff_sched
  import tx_bo_pkg::*;
#(
  parameter int unsigned LW   = 16,
  parameter int unsigned RW   = 16,
  parameter int unsigned TW   = 16,
  parameter int unsigned MB   = 8,
  parameter int unsigned SEED = 16'hACE1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [15:0]   load_i,
  input  logic [15:0]   min_gap_i,
  input  logic [15:0]   time_i,
  input  logic          tick_i,
  input  logic          tx_end_i,
  input  logic          tx_coll_i,
  input  logic          tx_fail_i,
  output logic [15:0]   load_o,
  output logic          load_we_o,
  output logic          go_o,
  output logic          ovf_o
);
  localparam int unsigned CW = ((TW > MB) ? TW : MB) + 1;

  bo_state_e     state_q;
  logic [LW-1:0] load_q, cur, new_load;
  logic [TW-1:0] last_q;
  logic [RW-1:0] rnd_nxt;
  logic [CW-1:0] wait_len;
  logic          eval, ovf, wait_start, wait_fire, wait_act;

  assign eval       = (state_q == ST_IDLE && req_i) || state_q == ST_RETRY;
  assign cur        = (state_q == ST_RETRY) ? load_q : LW'(load_i);
  assign wait_start = eval && !ovf && wait_len != '0;
  assign load_o     = 16'(load_q);

  tx_bo_rng #(.RW(RW), .SEED(SEED)) u_rng (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (eval),
    .nxt_o (rnd_nxt)
  );

  tx_bo_calc #(.LW(LW), .RW(RW), .TW(TW), .MB(MB), .CW(CW)) u_calc (
    .cur_i     (cur),
    .rnd_i     (rnd_nxt),
    .time_i    (TW'(time_i)),
    .last_i    (last_q),
    .gap_i     (TW'(min_gap_i)),
    .ovf_o     (ovf),
    .new_load_o(new_load),
    .wait_o    (wait_len)
  );

  tx_bo_wait #(.CW(CW)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wait_start),
    .len_i   (wait_len),
    .tick_i  (tick_i && state_q == ST_WAIT),
    .active_o(wait_act),
    .fire_o  (wait_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      load_q    <= '0;
      last_q    <= '0;
      load_we_o <= 1'b0;
      go_o      <= 1'b0;
      ovf_o     <= 1'b0;
    end else begin
      load_we_o <= 1'b0;
      go_o      <= 1'b0;
      ovf_o     <= 1'b0;
      if (eval) begin
        load_q    <= new_load;
        load_we_o <= 1'b1;
        if (ovf) begin
          ovf_o   <= 1'b1;
          state_q <= ST_IDLE;
        end else if (wait_len == '0) begin
          go_o    <= 1'b1;
          state_q <= ST_TX;
        end else begin
          state_q <= ST_WAIT;
        end
      end else begin
        unique case (state_q)
          ST_WAIT: if (wait_fire) begin
            go_o    <= 1'b1;
            state_q <= ST_TX;
          end
          ST_TX: if (tx_end_i) begin
            if (tx_coll_i) state_q <= ST_RETRY;
            else begin
              if (!tx_fail_i) last_q <= TW'(time_i);
              state_q <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r6_go_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> !go_o);
  a_r2_ovf_no_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> load_we_o && !go_o);
  a_r1_load_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_o |-> load_o[0]);
  a_r10_busy_no_eval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |=> !load_we_o);
  a_r6_wait_tracks_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> wait_act);
endmodule

// File: tb/test_tx_backoff_sched.sv
module test_tx_backoff_sched;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_i = 0, tick_i = 0, tx_end_i = 0, tx_coll_i = 0, tx_fail_i = 0;
  logic [15:0] load_i = '0, min_gap_i = '0, time_i = '0;
  logic [15:0] load_o;
  logic        load_we_o, go_o, ovf_o;

  tx_backoff_sched i_tx_backoff_sched (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .load_i(load_i),
    .min_gap_i(min_gap_i), .time_i(time_i), .tick_i(tick_i),
    .tx_end_i(tx_end_i), .tx_coll_i(tx_coll_i), .tx_fail_i(tx_fail_i),
    .load_o(load_o), .load_we_o(load_we_o), .go_o(go_o), .ovf_o(ovf_o)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic        ovf;
    logic [15:0] ld;
    int          w;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  int          n_chk = 0, n_fail = 0, tick_cnt = 0, we_seen = 0, we_exp = 0;
  logic [15:0] m_rnd = 16'hACE1, m_last = '0, m_held = '0;
  bit          waiting = 0, done = 0;
  int          tick_base = 0, pend_w = 0;
  string       pend_tag;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic void push_eval(logic [15:0] cur, string tag);
    exp_t        e;
    logic [7:0]  mask;
    logic [15:0] el;
    m_rnd = m_rnd * 16'd2053 + 16'd13849;
    mask  = cur[7:0] & m_rnd[15:8];
    el    = time_i - m_last;
    e.ovf = cur[15];
    e.ld  = {cur[14:0], 1'b1};
    e.tag = tag;
    if (mask != 0)          e.w = 2 * int'(mask);
    else if (el < min_gap_i) e.w = 2 * int'(min_gap_i - el);
    else                     e.w = 0;
    m_held = e.ld;
    we_exp++;
    exp_q.push_back(e);
  endfunction

  always @(posedge clk) if (tick_i) tick_cnt <= tick_cnt + 1;

  initial forever begin
    repeat (3) @(negedge clk) tick_i = 1'b0;
    @(negedge clk) tick_i = 1'b1;
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && load_we_o) begin
      we_seen++;
      if (exp_q.size() == 0) chk(0, "R10", "unexpected load write", load_o, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(load_o == e.ld, "R1", {e.tag, " load"}, load_o, e.ld);
        chk(ovf_o == e.ovf, "R2", {e.tag, " ovf"}, ovf_o, e.ovf);
        if (!e.ovf) begin
          waiting = 1; tick_base = tick_cnt; pend_w = e.w; pend_tag = e.tag;
        end
      end
    end
    if (rst_n && go_o) begin
      if (!waiting) chk(0, "R6", "go without pending attempt", 1, 0);
      else chk(tick_cnt - tick_base == pend_w, "R4/R5",
               {pend_tag, " ticks to go"}, tick_cnt - tick_base, pend_w);
      waiting = 0;
    end
  end

  task automatic settle();
    @(negedge clk);
    while (exp_q.size() != 0 || waiting) @(negedge clk);
  endtask

  task automatic attempt(logic [15:0] ld, string tag);
    push_eval(ld, tag);
    req_i = 1; load_i = ld;
    @(negedge clk);
    req_i = 0;
    chk(load_we_o == 1'b1, "R1", {tag, " strobe timing"}, load_we_o, 1);
    settle();
  endtask

  task automatic finish_tx(bit coll, bit fail, logic [15:0] t, string tag);
    time_i = t;
    if (coll) push_eval(m_held, tag);
    else if (!fail) m_last = t;
    tx_end_i = 1; tx_coll_i = coll; tx_fail_i = fail;
    @(negedge clk);
    tx_end_i = 0; tx_coll_i = 0; tx_fail_i = 0;
    if (coll) settle();
    else repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!go_o && !ovf_o && !load_we_o, "R11", "strobes in reset", {go_o, ovf_o, load_we_o}, 0);
    chk(load_o == 0, "R11", "load in reset", load_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R5 gap already met -> immediate go; R3 first draw from seed
    time_i = 16'd5; min_gap_i = 16'd3;
    attempt(16'h0000, "R5 gap met R3 seed");
    finish_tx(0, 0, 16'd100, "R8 success");
    // R5 shortfall of 3 -> 6 ticks
    time_i = 16'd101; min_gap_i = 16'd4;
    attempt(16'h0000, "R5 shortfall");
    finish_tx(0, 1, 16'd200, "R9 abort");
    // R9: last_end still 100, so shortfall 2 -> 4 ticks
    time_i = 16'd102;
    push_eval(16'h0000, "R9 last_end kept");
    req_i = 1; load_i = 16'h0000;
    @(negedge clk);
    req_i = 0;
    chk(load_we_o == 1'b1, "R1", "R9 strobe timing", load_we_o, 1);
    // R10 request while waiting must be ignored
    repeat (2) @(negedge clk);
    req_i = 1; load_i = 16'h1234;
    @(negedge clk);
    req_i = 0;
    chk(load_we_o == 1'b0, "R10", "strobe on busy request", load_we_o, 0);
    settle();
    finish_tx(0, 0, 16'hFFF0, "R8 success near wrap");
    // R5 wrapped elapsed 0x12 against gap 0x20 -> 28 ticks
    time_i = 16'h0002; min_gap_i = 16'h0020;
    attempt(16'h0000, "R5 wrap");
    finish_tx(0, 0, 16'h0010, "R8 success");
    // R4 masked random backoff
    min_gap_i = 16'h0000;
    attempt(16'h00FF, "R4 full mask");
    finish_tx(0, 0, 16'h0020, "R8 success");
    attempt(16'h0055, "R4 sparse mask");
    finish_tx(0, 0, 16'h0030, "R8 success");
    // R7 collision chain ending in R2 overflow
    attempt(16'h3FFF, "R7 first try");
    finish_tx(1, 0, 16'h0040, "R7 retry 7FFF");
    finish_tx(1, 1, 16'h0050, "R7 retry to R2 overflow");
    chk(!go_o, "R2", "no go after overflow", go_o, 0);
    // R2 direct overflow, then R3 generator kept advancing
    attempt(16'h8000, "R2 direct");
    attempt(16'h00FF, "R3 after overflow");
    finish_tx(0, 0, 16'h0060, "R8 success");
    repeat (4) @(negedge clk);

    chk(we_seen == we_exp, "R10", "total load writes", we_seen, we_exp);
    chk(exp_q.size() == 0, "R1", "leftover expectations", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule